// File: doc/BRIEF.md
# Single-Cycle 32-bit Scalar Core

This block is a small 32-bit processor that completes one instruction on every clock edge. A program counter selects a word from a read-only program store, and that store is filled from a parameter when the core is elaborated. The word is split into an ALU operation, an operand-mode bit and a branch bit, and its register fields are decoded. Two of the sixteen general registers are read combinationally and the ALU forms a result. At the next edge the core does one of two things: it writes the result into the destination register and steps the program counter, or, for a branch, it leaves every register untouched and picks the next program counter from the sign of the result.

The core has no data memory, no pipeline and no external bus. It is driven by its clock and an active-low reset. It exposes the program counter, the instruction being executed and the contents of every register for observation. Programs keep all of their working state in the sixteen registers.

Top module: `mini_risc_core`

## Requirements
- R1: Asserting `rst_n` low clears the program counter and all sixteen registers to zero at once, without waiting for a clock edge.
- R2: Instruction word layout is: bits 3:0 ALU operation, bit 4 second operand is the immediate (1) or register `rt` (0), bit 5 branch, bits 11:8 `rd`, bits 15:12 `rs`, bits 19:16 `rt`, bits 31:20 a 12-bit immediate that is zero-extended to 32 bits.
- R3: ALU codes with first operand A (`rs`) and second operand B: 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 ~A, 6 B, 7 A shifted right one place with a zero shifted in, 8 A shifted left one place, 9 all ones if A is non-zero else zero, 10 to 15 zero. All arithmetic wraps modulo 2^32.
- R4: A non-branch instruction writes its result into `rd` at the clock edge and advances the program counter by one, modulo 256.
- R5: A branch instruction writes no register, whatever its `rd` field holds.
- R6: A branch whose ALU result has bit 31 set loads the program counter with the low 8 bits of the zero-extended immediate. A branch whose result has bit 31 clear advances the program counter by one.
- R7: The program store has 256 words. Addresses at or beyond the loaded program length read as the all-zero word, which executes as R0 = R0 + R0.
- R8: `dbg_insn` shows the store word at the current program counter, also while reset is held. `dbg_regs` shows register n in bits n*32+31 down to n*32.
- R9: Register reads are combinational. An instruction that names the same register as source and destination computes with the value held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| dbg_pc | output | 8 | Current program counter |
| dbg_insn | output | 32 | Instruction word at the current program counter |
| dbg_regs | output | 512 | All sixteen registers, register n in bits n*32 +: 32 |

## Verification
A branch instruction carries a destination field like any other instruction. The register-write path and the program-counter redirect therefore both look at the same decoded word in the same cycle, and only one of them may act. The bench provokes this with branches whose `rd` names a live register: the loop-closing jump of the Fibonacci program names R15, whose value would turn to all ones if it were written. In a second program, a not-taken branch names R1 and a taken branch names R2. Each case is judged at the ports after the edge, by checking that the named register keeps its value while the program counter shows either the immediate target or the sequential address.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  localparam int XLEN     = 32;
  localparam int NUM_REGS = 16;
  localparam int RIDX_W   = $clog2(NUM_REGS);
  localparam int IMM_W    = 12;

  // instruction field positions
  localparam int F_OP_LO   = 0;
  localparam int F_IMMSEL  = 4;
  localparam int F_BRANCH  = 5;
  localparam int F_RD_LO   = 8;
  localparam int F_RS_LO   = 12;
  localparam int F_RT_LO   = 16;
  localparam int F_IMM_LO  = 20;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_NOTA  = 4'd5,
    OP_PASSB = 4'd6,
    OP_SHR1  = 4'd7,
    OP_SHL1  = 4'd8,
    OP_ANY   = 4'd9
  } alu_op_e;

  typedef struct packed {
    alu_op_e           op;
    logic              use_imm;
    logic              is_branch;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rt;
    logic [XLEN-1:0]   imm;
  } decoded_t;

endpackage

// File: rtl/mrc_rom.sv
module mrc_rom #(
  parameter int DEPTH    = 256,
  parameter int PROG_LEN = 1,
  parameter logic [PROG_LEN*mrc_pkg::XLEN-1:0] PROG_IMAGE = '0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]           addr,
  output logic [mrc_pkg::XLEN-1:0] word
);
  import mrc_pkg::*;

  logic [XLEN-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    if (i < PROG_LEN) begin : g_loaded
      assign table_w[i] = PROG_IMAGE[i*XLEN +: XLEN];
    end else begin : g_blank
      assign table_w[i] = '0;
    end
  end

  assign word = table_w[addr];

endmodule

// File: rtl/mrc_decode.sv
module mrc_decode (
  input  logic [mrc_pkg::XLEN-1:0] insn,
  output mrc_pkg::decoded_t        dec
);
  import mrc_pkg::*;

  always_comb begin
    dec.op        = alu_op_e'(insn[F_OP_LO +: 4]);
    dec.use_imm   = insn[F_IMMSEL];
    dec.is_branch = insn[F_BRANCH];
    dec.rd        = insn[F_RD_LO +: RIDX_W];
    dec.rs        = insn[F_RS_LO +: RIDX_W];
    dec.rt        = insn[F_RT_LO +: RIDX_W];
    dec.imm       = {{(XLEN-IMM_W){1'b0}}, insn[F_IMM_LO +: IMM_W]};
  end

endmodule

// File: rtl/mrc_alu.sv
module mrc_alu #(
  parameter int W = 32
) (
  input  mrc_pkg::alu_op_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     res
);
  import mrc_pkg::*;

  always_comb begin
    unique case (op)
      OP_ADD:   res = a + b;
      OP_SUB:   res = a - b;
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_NOTA:  res = ~a;
      OP_PASSB: res = b;
      OP_SHR1:  res = {1'b0, a[W-1:1]};
      OP_SHL1:  res = {a[W-2:0], 1'b0};
      OP_ANY:   res = {W{|a}};
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/mrc_regfile.sv
module mrc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [W-1:0]    wr_data,
  input  logic [IW-1:0]   rd_idx_a,
  input  logic [IW-1:0]   rd_idx_b,
  output logic [W-1:0]    rd_data_a,
  output logic [W-1:0]    rd_data_b,
  output logic [NREG-1:0] wr_sel,
  output logic [NREG*W-1:0] all_regs
);

  logic [W-1:0] reg_q [NREG];

  // per-entry clock enable
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      wr_sel[i] = wr_en && (wr_idx == IW'(i));
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[i] <= '0;
      end else if (wr_sel[i]) begin
        reg_q[i] <= wr_data;
      end
    end
    assign all_regs[i*W +: W] = reg_q[i];
  end

  assign rd_data_a = reg_q[rd_idx_a];
  assign rd_data_b = reg_q[rd_idx_b];

endmodule

// File: rtl/mini_risc_core.sv
module mini_risc_core #(
  parameter int ROM_DEPTH = 256,
  parameter int PROG_LEN  = 1,
  parameter logic [PROG_LEN*32-1:0] PROG_IMAGE = '0,
  localparam int PC_W = $clog2(ROM_DEPTH),
  localparam int NREG = mrc_pkg::NUM_REGS,
  localparam int XW   = mrc_pkg::XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   dbg_pc,
  output logic [XW-1:0]     dbg_insn,
  output logic [NREG*XW-1:0] dbg_regs
);
  import mrc_pkg::*;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [XW-1:0]   insn;
  decoded_t        dec;
  logic [XW-1:0]   opnd_a;
  logic [XW-1:0]   rt_val;
  logic [XW-1:0]   opnd_b;
  logic [XW-1:0]   alu_res;
  logic            rf_we;
  logic [NREG-1:0] rf_wr_sel;
  logic            take_branch;
  logic [PC_W-1:0] branch_tgt;

  mrc_rom #(
    .DEPTH     (ROM_DEPTH),
    .PROG_LEN  (PROG_LEN),
    .PROG_IMAGE(PROG_IMAGE)
  ) u_rom (
    .addr(pc_q),
    .word(insn)
  );

  mrc_decode u_dec (
    .insn(insn),
    .dec (dec)
  );

  mrc_regfile #(
    .W   (XW),
    .NREG(NREG)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (rf_we),
    .wr_idx   (dec.rd),
    .wr_data  (alu_res),
    .rd_idx_a (dec.rs),
    .rd_idx_b (dec.rt),
    .rd_data_a(opnd_a),
    .rd_data_b(rt_val),
    .wr_sel   (rf_wr_sel),
    .all_regs (dbg_regs)
  );

  assign opnd_b = dec.use_imm ? dec.imm : rt_val;

  mrc_alu #(.W(XW)) u_alu (
    .op (dec.op),
    .a  (opnd_a),
    .b  (opnd_b),
    .res(alu_res)
  );

  assign rf_we       = !dec.is_branch;
  assign take_branch = dec.is_branch && alu_res[XW-1];
  assign branch_tgt  = dec.imm[PC_W-1:0];

  // next-state
  always_comb begin
    pc_d = pc_q + 1'b1;
    if (take_branch) begin
      pc_d = branch_tgt;
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign dbg_pc   = pc_q;
  assign dbg_insn = insn;

endmodule

// File: rtl/mini_risc_core_chk.sv
module mini_risc_core_chk #(
  parameter int PC_W = 8,
  parameter int XW   = 32,
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pc,
  input logic              is_branch,
  input logic              res_msb,
  input logic [PC_W-1:0]   tgt,
  input logic [NREG-1:0]   wr_sel,
  input logic [NREG*XW-1:0] regs
);

  // R4: sequential flow on ordinary instructions
  assert_seq_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_branch |=> pc == $past(pc) + 1'b1);

  // R4: at most one register written per edge
  assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R5: branch selects no register
  assert_branch_no_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> wr_sel == '0);

  // R5: register contents survive a branch
  assert_branch_keeps_regs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |=> regs == $past(regs));

  // R6: taken branch lands on the immediate target
  assert_taken_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && res_msb) |=> pc == $past(tgt));

  // R6: not-taken branch falls through
  assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !res_msb) |=> pc == $past(pc) + 1'b1);

endmodule

bind mini_risc_core mini_risc_core_chk #(
  .PC_W(PC_W),
  .XW  (XW),
  .NREG(NREG)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc       (pc_q),
  .is_branch(dec.is_branch),
  .res_msb  (alu_res[XW-1]),
  .tgt      (branch_tgt),
  .wr_sel   (rf_wr_sel),
  .regs     (dbg_regs)
);

// File: tb/mini_risc_core_test.sv
`timescale 1ns/1ps
module mini_risc_core_test;

  // Fibonacci loop: LD R1,0 / LD R2,1 / R3=R1+R2 / R1=R2 / R2=R3 / branch(~R0) to 2 with rd=R15
  localparam int FIB_LEN = 6;
  localparam logic [FIB_LEN*32-1:0] FIB_IMG = {
    32'h00200F25, 32'h00003210, 32'h00002110,
    32'h00021300, 32'h00100216, 32'h00000116
  };

  // ALU and branch exercise program, word 0 in the low bits
  localparam int OPS_LEN = 18;
  localparam logic [OPS_LEN*32-1:0] OPS_IMG = {
    32'h00900D16, // 17 LD R13,9 (must be skipped)
    32'h0C820221, // 16 branch R0-R2 (negative) to 200, rd=R2
    32'h04000129, // 15 branch any(R0) (zero) to 64, rd=R1
    32'h00021E0F, // 14 reserved op 15 -> R14
    32'h00700E16, // 13 LD R14,7
    32'h00000C09, // 12 any(R0) -> R12
    32'h0002BB01, // 11 R11 = R11 - R2
    32'h00002B09, // 10 any(R2) -> R11
    32'h00004A08, //  9 R10 = R4 << 1
    32'h00004907, //  8 R9 = R4 >> 1
    32'h00002805, //  7 R8 = ~R2
    32'h00021704, //  6 R7 = R1 ^ R2
    32'h0A002613, //  5 R6 = R2 | 0xA0
    32'h00021502, //  4 R5 = R1 & R2
    32'h00012401, //  3 R4 = R2 - R1
    32'h00021301, //  2 R3 = R1 - R2
    32'h00500216, //  1 LD R2,5
    32'hFFF00116  //  0 LD R1,0xFFF
  };

  // final register file expected after the exercise program
  localparam logic [31:0] OPS_EXP [16] = '{
    32'h00000000, 32'h00000FFF, 32'h00000005, 32'h00000FFA,
    32'hFFFFF006, 32'h00000005, 32'h000000A5, 32'h00000FFA,
    32'hFFFFFFFA, 32'h7FFFF803, 32'hFFFFE00C, 32'hFFFFFFFA,
    32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000
  };

  // Fibonacci numbers F(1)..F(13)
  localparam logic [31:0] FIB_EXP [13] = '{
    32'd1, 32'd1, 32'd2, 32'd3, 32'd5, 32'd8, 32'd13,
    32'd21, 32'd34, 32'd55, 32'd89, 32'd144, 32'd233
  };

  logic         clk;
  logic         rst_n;
  logic [7:0]   fib_pc,   ops_pc;
  logic [31:0]  fib_insn, ops_insn;
  logic [511:0] fib_regs, ops_regs;

  int checks;
  int failures;
  bit done;

  mini_risc_core #(.PROG_LEN(FIB_LEN), .PROG_IMAGE(FIB_IMG)) uut (
    .clk(clk), .rst_n(rst_n),
    .dbg_pc(fib_pc), .dbg_insn(fib_insn), .dbg_regs(fib_regs)
  );

  mini_risc_core #(.PROG_LEN(OPS_LEN), .PROG_IMAGE(OPS_IMG)) uut_ops (
    .clk(clk), .rst_n(rst_n),
    .dbg_pc(ops_pc), .dbg_insn(ops_insn), .dbg_regs(ops_regs)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] reg_at(input logic [511:0] flat, input int idx);
    return flat[idx*32 +: 32];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state, R8 instruction visible during reset
    check("R1 fib pc reset", {24'b0, fib_pc}, 32'd0);
    check("R1 ops pc reset", {24'b0, ops_pc}, 32'd0);
    for (int r = 0; r < 16; r++) begin
      check("R1 register reset", reg_at(ops_regs, r), 32'd0);
    end
    check("R8 insn at pc0 in reset", ops_insn, 32'hFFF00116);

    rst_n = 1'b1;

    step(15);
    check("R8 insn shown at pc15", ops_insn, 32'h04000129);
    check("R4 pc after 15 edges", {24'b0, ops_pc}, 32'd15);
    check("R2 immediate zero-extended", reg_at(ops_regs, 1), 32'h00000FFF);
    check("R9 same-register read-before-write", reg_at(ops_regs, 11), 32'hFFFFFFFA);

    step(1);
    check("R6 not-taken branch falls through", {24'b0, ops_pc}, 32'd16);
    check("R5 not-taken branch leaves rd=R1", reg_at(ops_regs, 1), 32'h00000FFF);

    step(1);
    check("R6 taken branch to immediate", {24'b0, ops_pc}, 32'd200);
    check("R5 taken branch leaves rd=R2", reg_at(ops_regs, 2), 32'h00000005);
    check("R7 unloaded address reads zero", ops_insn, 32'h00000000);

    step(3);
    check("R7 zero word advances pc", {24'b0, ops_pc}, 32'd203);
    for (int r = 0; r < 16; r++) begin
      check("R3 ALU result table", reg_at(ops_regs, r), OPS_EXP[r]);
    end

    // R1 asynchronous clear mid-run
    rst_n = 1'b0;
    #1;
    check("R1 async clear pc", {24'b0, ops_pc}, 32'd0);
    check("R1 async clear R4", reg_at(ops_regs, 4), 32'd0);
    check("R1 async clear R11", reg_at(ops_regs, 11), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    step(2);
    check("R4 fib R1 init", reg_at(fib_regs, 1), 32'd0);
    check("R4 fib R2 init", reg_at(fib_regs, 2), 32'd1);
    for (int it = 1; it <= 12; it++) begin
      step(4);
      check("R4 fib R1 value", reg_at(fib_regs, 1), FIB_EXP[it-1]);
      check("R4 fib R2 value", reg_at(fib_regs, 2), FIB_EXP[it]);
      check("R6 loop returns to 2", {24'b0, fib_pc}, 32'd2);
      check("R5 jump rd=R15 untouched", reg_at(fib_regs, 15), 32'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule